// File: doc/BRIEF.md
# BCD Calendar Real-Time Clock with Alarm

This block is a register-mapped calendar clock. A one-pulse-per-second tick input advances BCD counters for seconds, minutes, hours, day of month, month and two-digit year, plus a weekday counter. The calendar knows month lengths and the four-year February rule. A byte-wide register bus reads and writes every counter, a full-date alarm, a control byte, a status byte, an interrupt-enable byte and two stored compensation bytes.

Software starts and stops counting with one control bit. It stops the clock to load a new time without a carry landing part-way through the load. To read a coherent time while the clock runs, software sets the snapshot control bit. That copies all counters into shadow registers, and the time addresses return the copy for as long as the bit stays set. Status flags record second, minute, hour and day rollovers, alarm matches and power-up. Software clears each flag by writing a one to it. A single level interrupt output combines the alarm flag and one selectable periodic flag.

Top module: `bcd_calendar_rtc`

## Requirements
- R1: After reset the time reads 00:00:00 with day 01, month 01, year 00 and weekday 0. The control byte reads 0x00 (stopped), status reads 0x80 (power-up flag only) and irq is low.
- R2: The register offsets are time 0x00 (seconds), 0x01 (minutes), 0x02 (hours), 0x03 (day), 0x04 (month), 0x05 (year) and 0x06 (weekday). Alarm seconds through alarm year sit at 0x07 to 0x0C in the same field order. Control is at 0x0D, status at 0x0E, interrupt enable at 0x0F and the compensation low and high bytes at 0x10 and 0x11. Alarm, compensation and control bytes read back as written. Interrupt enable reads back its low four bits with the upper bits as zero. Any other address reads 0x00.
- R3: While control bit 0 is 1, each tick advances the time by one second. While it is 0, ticks leave every counter unchanged. Status bit 1 reads as control bit 0.
- R4: Seconds and minutes count 00 to 59 in BCD and hours count 00 to 23. Each wrap carries into the next field.
- R5: At the end of a day, the day field returns to 01 once it has reached the month's length; otherwise it increments. Months 04, 06, 09 and 11 have 30 days, February has 29 days when the two-digit year is divisible by 4 and 28 otherwise, and the other months have 31. Month 12 wraps to 01 and carries into the year, and year 99 wraps to 00.
- R6: The weekday counts 0 to 6, advances by one at every midnight and wraps from 6 to 0.
- R7: Writing the control byte with bit 6 set copies all seven counters into shadow registers. While control bit 6 is 1, reads of 0x00 to 0x06 return that copy. While it is 0 they return the live counters.
- R8: Every counted tick sets status bit 2. A seconds wrap sets bit 3, a minutes wrap sets bit 4 and an hours wrap (midnight) sets bit 5.
- R9: Status bit 6 is set by the counted tick whose new time equals all six alarm registers (seconds through year). The weekday takes no part in the match.
- R10: Writing a 1 to any of status bits 2 to 7 clears that flag. Zero bits leave flags unchanged, and writes to bits 0 and 1 have no effect.
- R11: In the interrupt-enable byte, bits [1:0] pick the periodic flag: 0 selects status bit 2, 1 bit 3, 2 bit 4 and 3 bit 5. Bit 2 enables the periodic interrupt and bit 3 enables the alarm interrupt. irq is high while an enabled selected flag is set and drops when software clears it.
- R12: Control bits 1 to 5 and 7 and the compensation bytes are only stored. With them set, a tick still advances the time by exactly one second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| bus_addr | input | ADDR_W | Register address for read and write |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| irq | output | 1 | Level interrupt request |

## Verification
The bench builds the block with its defaults: a 5-bit address and a 7-day week. At that size every month end of seven years (leap, non-leap, 96 and 99) is stepped over in turn, along with the day before each month end. A 150-tick run crosses a year wrap and a weekday wrap. All four periodic codes are driven through both a plain second and a full midnight rollover, so every calendar boundary and interrupt selection is compared against an arithmetic model in binary.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int OFS_SEC   = 'h00;
  localparam int OFS_WDAY  = 'h06;
  localparam int OFS_ALM   = 'h07;
  localparam int OFS_CTRL  = 'h0D;
  localparam int OFS_STAT  = 'h0E;
  localparam int OFS_IEN   = 'h0F;
  localparam int OFS_CMPLO = 'h10;
  localparam int OFS_CMPHI = 'h11;

  localparam int CTRL_RUN  = 0;
  localparam int CTRL_SNAP = 6;

  localparam int IEN_TIMER = 2;
  localparam int IEN_ALARM = 3;

  // flag bank index k corresponds to status bit k+2
  localparam int NFLAGS    = 6;
  localparam int FLG_SEC   = 0;
  localparam int FLG_MIN   = 1;
  localparam int FLG_HOUR  = 2;
  localparam int FLG_DAY   = 3;
  localparam int FLG_ALARM = 4;
  localparam int FLG_PWR   = 5;

  localparam int NFIELDS = 6;

  typedef struct packed {
    logic [7:0] sec;
    logic [7:0] min;
    logic [7:0] hour;
    logic [7:0] day;
    logic [7:0] mon;
    logic [7:0] year;
  } rtc_date_t;

  typedef struct packed {
    rtc_date_t nxt;
    logic      min_evt;
    logic      hour_evt;
    logic      day_evt;
  } rtc_step_t;

  localparam rtc_date_t DATE_RESET = '{sec: 8'h00, min: 8'h00, hour: 8'h00,
                                       day: 8'h01, mon: 8'h01, year: 8'h00};

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'h9) return {v[7:4] + 4'h1, 4'h0};
    return {v[7:4], v[3:0] + 4'h1};
  endfunction

  // 10 = 2 (mod 4), so year mod 4 = (2*tens + ones) mod 4
  function automatic logic leap_year(input logic [7:0] year);
    return (2'({year[4], 1'b0}) + year[1:0]) == 2'b00;
  endfunction

  function automatic logic [7:0] month_len(input logic [7:0] mon, input logic [7:0] year);
    case (mon)
      8'h02:                      return leap_year(year) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic rtc_step_t rtc_step(input rtc_date_t c);
    rtc_step_t r;
    r.nxt      = c;
    r.min_evt  = 1'b0;
    r.hour_evt = 1'b0;
    r.day_evt  = 1'b0;
    if (c.sec >= 8'h59) begin
      r.nxt.sec = 8'h00;
      r.min_evt = 1'b1;
      if (c.min >= 8'h59) begin
        r.nxt.min  = 8'h00;
        r.hour_evt = 1'b1;
        if (c.hour >= 8'h23) begin
          r.nxt.hour = 8'h00;
          r.day_evt  = 1'b1;
          if (c.day >= month_len(c.mon, c.year)) begin
            r.nxt.day = 8'h01;
            if (c.mon >= 8'h12) begin
              r.nxt.mon  = 8'h01;
              r.nxt.year = (c.year >= 8'h99) ? 8'h00 : bcd_inc(c.year);
            end else begin
              r.nxt.mon = bcd_inc(c.mon);
            end
          end else begin
            r.nxt.day = bcd_inc(c.day);
          end
        end else begin
          r.nxt.hour = bcd_inc(c.hour);
        end
      end else begin
        r.nxt.min = bcd_inc(c.min);
      end
    end else begin
      r.nxt.sec = bcd_inc(c.sec);
    end
    return r;
  endfunction

endpackage

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
  import rtc_pkg::*;
#(
  parameter int WEEK_LEN = 7
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        advance,
  input  logic [NFIELDS-1:0]          fld_wr,
  input  logic                        wday_wr,
  input  logic [7:0]                  wr_val,
  output rtc_date_t                   now_q,
  output logic [$clog2(WEEK_LEN)-1:0] wday_q,
  output rtc_date_t                   upcoming,
  output logic                        evt_sec,
  output logic                        evt_min,
  output logic                        evt_hour,
  output logic                        evt_day
);

  localparam int WD_W = $clog2(WEEK_LEN);

  rtc_step_t step;

  always_comb step = rtc_step(now_q);

  assign upcoming = step.nxt;
  assign evt_sec  = advance;
  assign evt_min  = advance & step.min_evt;
  assign evt_hour = advance & step.hour_evt;
  assign evt_day  = advance & step.day_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      now_q  <= DATE_RESET;
      wday_q <= '0;
    end else begin
      if (advance) begin
        now_q <= step.nxt;
        if (step.day_evt)
          wday_q <= (wday_q == WD_W'(WEEK_LEN - 1)) ? '0 : wday_q + 1'b1;
      end
      if (fld_wr[0]) now_q.sec  <= wr_val;
      if (fld_wr[1]) now_q.min  <= wr_val;
      if (fld_wr[2]) now_q.hour <= wr_val;
      if (fld_wr[3]) now_q.day  <= wr_val;
      if (fld_wr[4]) now_q.mon  <= wr_val;
      if (fld_wr[5]) now_q.year <= wr_val;
      if (wday_wr)   wday_q     <= wr_val[WD_W-1:0];
    end
  end

  a_r3_frozen_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!advance && fld_wr == '0 && !wday_wr) |=> ($stable(now_q) && $stable(wday_q)));

  a_r4_sec_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && fld_wr == '0 && now_q.sec == 8'h59) |=> (now_q.sec == 8'h00));

  a_r6_weekday_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !wday_wr && now_q.hour == 8'h23 && now_q.min == 8'h59 &&
     now_q.sec == 8'h59 && wday_q == WD_W'(WEEK_LEN - 1)) |=> (wday_q == '0));

endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
  import rtc_pkg::*;
(
  input  logic      advance,
  input  rtc_date_t upcoming,
  input  rtc_date_t alarm,
  output logic      hit
);

  logic [NFIELDS-1:0][7:0] up_arr;
  logic [NFIELDS-1:0][7:0] al_arr;
  logic [NFIELDS-1:0]      field_eq;

  assign up_arr = upcoming;
  assign al_arr = alarm;

  for (genvar i = 0; i < NFIELDS; i++) begin : g_cmp
    assign field_eq[i] = (up_arr[i] == al_arr[i]);
  end

  assign hit = advance & (&field_eq);

endmodule

// File: rtl/rtc_status_flags.sv
module rtc_status_flags #(
  parameter int               N         = 6,
  parameter logic [N-1:0]     RESET_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flags_q
);

  for (genvar k = 0; k < N; k++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)        flags_q[k] <= RESET_VAL[k];
      else if (set_i[k]) flags_q[k] <= 1'b1;
      else if (clr_i[k]) flags_q[k] <= 1'b0;
    end

    a_r8_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[k] |=> flags_q[k]);

    a_r10_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[k] && !set_i[k]) |=> !flags_q[k]);
  end

endmodule

// File: rtl/bcd_calendar_rtc.sv
module bcd_calendar_rtc
  import rtc_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int WEEK_LEN = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1hz,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              irq
);

  localparam int WD_W = $clog2(WEEK_LEN);

  logic [7:0]              ctrl_q;
  logic [3:0]              ien_q;
  logic [7:0]              cmp_lo_q, cmp_hi_q;
  logic [NFIELDS-1:0][7:0] alarm_q;
  rtc_date_t               alarm_date;
  rtc_date_t               snap_q;
  logic [WD_W-1:0]         snap_wday_q;

  rtc_date_t               now_q, upcoming, view;
  logic [WD_W-1:0]         wday_q, view_wday;
  logic                    advance;
  logic                    evt_sec, evt_min, evt_hour, evt_day, alarm_hit;
  logic [NFIELDS-1:0]      fld_wr, alm_wr;
  logic                    wday_wr, ctrl_wr, stat_wr, ien_wr, cmplo_wr, cmphi_wr;
  logic                    snap_take;
  logic [NFLAGS-1:0]       flag_set, flag_clr, flags_q;
  logic                    periodic_sel;

  // ---------------- write decode ----------------
  for (genvar i = 0; i < NFIELDS; i++) begin : g_dec
    assign fld_wr[i] = bus_wr && (bus_addr == ADDR_W'(OFS_SEC + i));
    assign alm_wr[i] = bus_wr && (bus_addr == ADDR_W'(OFS_ALM + i));

    always_ff @(posedge clk) begin
      if (!rst_n)        alarm_q[i] <= 8'h00;
      else if (alm_wr[i]) alarm_q[i] <= bus_wdata;
    end
  end

  assign wday_wr  = bus_wr && (bus_addr == ADDR_W'(OFS_WDAY));
  assign ctrl_wr  = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
  assign stat_wr  = bus_wr && (bus_addr == ADDR_W'(OFS_STAT));
  assign ien_wr   = bus_wr && (bus_addr == ADDR_W'(OFS_IEN));
  assign cmplo_wr = bus_wr && (bus_addr == ADDR_W'(OFS_CMPLO));
  assign cmphi_wr = bus_wr && (bus_addr == ADDR_W'(OFS_CMPHI));

  assign alarm_date = '{sec: alarm_q[0], min: alarm_q[1], hour: alarm_q[2],
                        day: alarm_q[3], mon: alarm_q[4], year: alarm_q[5]};

  // ---------------- control registers ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= 8'h00;
      ien_q    <= 4'h0;
      cmp_lo_q <= 8'h00;
      cmp_hi_q <= 8'h00;
    end else begin
      if (ctrl_wr)  ctrl_q   <= bus_wdata;
      if (ien_wr)   ien_q    <= bus_wdata[3:0];
      if (cmplo_wr) cmp_lo_q <= bus_wdata;
      if (cmphi_wr) cmp_hi_q <= bus_wdata;
    end
  end

  assign advance   = tick_1hz & ctrl_q[CTRL_RUN];
  assign snap_take = ctrl_wr & bus_wdata[CTRL_SNAP];

  // ---------------- counters ----------------
  rtc_calendar_core #(.WEEK_LEN(WEEK_LEN)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .advance  (advance),
    .fld_wr   (fld_wr),
    .wday_wr  (wday_wr),
    .wr_val   (bus_wdata),
    .now_q    (now_q),
    .wday_q   (wday_q),
    .upcoming (upcoming),
    .evt_sec  (evt_sec),
    .evt_min  (evt_min),
    .evt_hour (evt_hour),
    .evt_day  (evt_day)
  );

  rtc_alarm_match u_alarm (
    .advance  (advance),
    .upcoming (upcoming),
    .alarm    (alarm_date),
    .hit      (alarm_hit)
  );

  // ---------------- snapshot shadow ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap_q      <= DATE_RESET;
      snap_wday_q <= '0;
    end else if (snap_take) begin
      snap_q      <= now_q;
      snap_wday_q <= wday_q;
    end
  end

  assign view      = ctrl_q[CTRL_SNAP] ? snap_q      : now_q;
  assign view_wday = ctrl_q[CTRL_SNAP] ? snap_wday_q : wday_q;

  // ---------------- status flags ----------------
  always_comb begin
    flag_set            = '0;
    flag_set[FLG_SEC]   = evt_sec;
    flag_set[FLG_MIN]   = evt_min;
    flag_set[FLG_HOUR]  = evt_hour;
    flag_set[FLG_DAY]   = evt_day;
    flag_set[FLG_ALARM] = alarm_hit;
    flag_clr            = stat_wr ? bus_wdata[7:2] : '0;
  end

  rtc_status_flags #(.N(NFLAGS), .RESET_VAL(NFLAGS'(1) << FLG_PWR)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (flag_set),
    .clr_i   (flag_clr),
    .flags_q (flags_q)
  );

  // ---------------- interrupt ----------------
  assign periodic_sel = flags_q[ien_q[1:0]];
  assign irq = (ien_q[IEN_TIMER] & periodic_sel) | (ien_q[IEN_ALARM] & flags_q[FLG_ALARM]);

  // ---------------- read mux ----------------
  always_comb begin
    case (bus_addr)
      ADDR_W'(OFS_SEC + 0): bus_rdata = view.sec;
      ADDR_W'(OFS_SEC + 1): bus_rdata = view.min;
      ADDR_W'(OFS_SEC + 2): bus_rdata = view.hour;
      ADDR_W'(OFS_SEC + 3): bus_rdata = view.day;
      ADDR_W'(OFS_SEC + 4): bus_rdata = view.mon;
      ADDR_W'(OFS_SEC + 5): bus_rdata = view.year;
      ADDR_W'(OFS_WDAY):    bus_rdata = 8'(view_wday);
      ADDR_W'(OFS_ALM + 0): bus_rdata = alarm_q[0];
      ADDR_W'(OFS_ALM + 1): bus_rdata = alarm_q[1];
      ADDR_W'(OFS_ALM + 2): bus_rdata = alarm_q[2];
      ADDR_W'(OFS_ALM + 3): bus_rdata = alarm_q[3];
      ADDR_W'(OFS_ALM + 4): bus_rdata = alarm_q[4];
      ADDR_W'(OFS_ALM + 5): bus_rdata = alarm_q[5];
      ADDR_W'(OFS_CTRL):    bus_rdata = ctrl_q;
      ADDR_W'(OFS_STAT):    bus_rdata = {flags_q, ctrl_q[CTRL_RUN], 1'b0};
      ADDR_W'(OFS_IEN):     bus_rdata = {4'h0, ien_q};
      ADDR_W'(OFS_CMPLO):   bus_rdata = cmp_lo_q;
      ADDR_W'(OFS_CMPHI):   bus_rdata = cmp_hi_q;
      default:              bus_rdata = 8'h00;
    endcase
  end

  // ---------------- assertions ----------------
  a_r7_shadow_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_take |=> ($stable(snap_q) && $stable(snap_wday_q)));

  a_r10_pwr_clears_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flags_q[FLG_PWR]) |-> $past(stat_wr && bus_wdata[7]));

  a_r9_alarm_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags_q[FLG_ALARM]) |-> $past(advance));

  a_r11_irq_falls_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(bus_wr));

  a_r3_run_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags_q[FLG_SEC]) |-> $past(ctrl_q[CTRL_RUN]));

endmodule

// File: tb/bcd_calendar_rtc_test.sv
module bcd_calendar_rtc_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  int ms, mm, mh, md, mmo, my, mw;

  always #10 clk = ~clk;

  bcd_calendar_rtc #(.ADDR_W(5), .WEEK_LEN(7)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_1hz  (tick),
    .bus_addr  (addr),
    .bus_wr    (wr),
    .bus_wdata (wdata),
    .bus_rdata (rdata),
    .irq       (irq)
  );

  function automatic logic [7:0] bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int dim(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  function automatic logic [55:0] model_word();
    return {bcd(ms), bcd(mm), bcd(mh), bcd(md), bcd(mmo), bcd(my), bcd(mw)};
  endfunction

  task automatic model_tick();
    ms++;
    if (ms == 60) begin
      ms = 0; mm++;
      if (mm == 60) begin
        mm = 0; mh++;
        if (mh == 24) begin
          mh = 0; mw = (mw + 1) % 7; md++;
          if (md > dim(mmo, my)) begin
            md = 1; mmo++;
            if (mmo == 13) begin
              mmo = 1; my = (my + 1) % 100;
            end
          end
        end
      end
    end
  endtask

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input int a, input logic [7:0] d);
    @(negedge clk);
    addr  = 5'(a);
    wdata = d;
    wr    = 1'b1;
    @(negedge clk);
    wr    = 1'b0;
  endtask

  task automatic bus_read(input int a, output logic [7:0] d);
    @(negedge clk);
    addr = 5'(a);
    #2 d = rdata;
  endtask

  task automatic read_time(output logic [55:0] t);
    logic [7:0] b;
    t = '0;
    for (int i = 0; i < 7; i++) begin
      bus_read(i, b);
      t = {t[47:0], b};
    end
  endtask

  task automatic do_tick();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic set_time(input int y, input int mo, input int d, input int h,
                          input int mi, input int s, input int w);
    bus_write('h0D, 8'h00);
    bus_write('h00, bcd(s));
    bus_write('h01, bcd(mi));
    bus_write('h02, bcd(h));
    bus_write('h03, bcd(d));
    bus_write('h04, bcd(mo));
    bus_write('h05, bcd(y));
    bus_write('h06, bcd(w));
    bus_write('h0D, 8'h01);
    ms = s; mm = mi; mh = h; md = d; mmo = mo; my = y; mw = w;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [55:0] t, snap;
    logic [7:0]  b;
    int yrs[7] = '{0, 1, 2, 3, 4, 96, 99};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    ms = 0; mm = 0; mh = 0; md = 1; mmo = 1; my = 0; mw = 0;
    read_time(t);
    check("R1 time", t, model_word());
    bus_read('h0D, b); check("R1 ctrl", b, 8'h00);
    bus_read('h0E, b); check("R1 status", b, 8'h80);
    check("R1 irq", irq, 1'b0);

    // R10 power-up flag clears by write-one
    bus_write('h0E, 8'h80);
    bus_read('h0E, b); check("R10 pwr clear", b, 8'h00);

    // R3 ticks ignored while stopped
    do_tick(); do_tick();
    read_time(t); check("R3 stopped", t, model_word());
    bus_read('h0E, b); check("R3 run bit off", b, 8'h00);

    // R2 / R12 register storage
    for (int i = 0; i < 6; i++) bus_write('h07 + i, 8'h11 + 8'(i));
    for (int i = 0; i < 6; i++) begin
      bus_read('h07 + i, b); check("R2 alarm rw", b, 8'h11 + 8'(i));
    end
    bus_write('h10, 8'hA5); bus_write('h11, 8'h5A);
    bus_read('h10, b); check("R2 comp lo", b, 8'hA5);
    bus_read('h11, b); check("R2 comp hi", b, 8'h5A);
    bus_write('h0F, 8'hF0);
    bus_read('h0F, b); check("R2 ien upper zero", b, 8'h00);
    bus_write('h0F, 8'hF3);
    bus_read('h0F, b); check("R2 ien low bits", b, 8'h03);
    bus_write('h0F, 8'h00);
    bus_read('h12, b); check("R2 unmapped 12", b, 8'h00);
    bus_read('h1F, b); check("R2 unmapped 1F", b, 8'h00);
    bus_write('h0D, 8'hBE);
    bus_read('h0D, b); check("R12 ctrl readback", b, 8'hBE);
    do_tick();
    read_time(t); check("R12 stopped with extra bits", t, model_word());
    bus_write('h0D, 8'hBF);
    bus_read('h0E, b); check("R3 run bit on", b[1], 1'b1);
    do_tick(); model_tick();
    read_time(t); check("R12 one second only", t, model_word());
    bus_write('h0A, 8'h00);   // alarm day 0: never matches
    bus_write('h0D, 8'h01);

    // R4 R5 R6 continuous run across year and weekday wrap
    set_time(99, 12, 31, 23, 58, 0, 6);
    for (int n = 0; n < 150; n++) begin
      do_tick(); model_tick();
      read_time(t); check("R4 R5 R6 run", t, model_word());
    end

    // R5 month-end sweep
    foreach (yrs[k]) begin
      for (int m = 1; m <= 12; m++) begin
        set_time(yrs[k], m, dim(m, yrs[k]), 23, 59, 59, 3);
        do_tick(); model_tick();
        read_time(t); check("R5 month end", t, model_word());
        set_time(yrs[k], m, dim(m, yrs[k]) - 1, 23, 59, 59, 5);
        do_tick(); model_tick();
        read_time(t); check("R5 day before end", t, model_word());
      end
    end

    // R8 event flags
    set_time(20, 7, 9, 12, 34, 56, 1);
    bus_write('h0E, 8'hFC);
    do_tick(); bus_read('h0E, b); check("R8 second only", b, 8'h06);
    set_time(20, 7, 9, 12, 34, 59, 1);
    bus_write('h0E, 8'hFC);
    do_tick(); bus_read('h0E, b); check("R8 minute", b, 8'h0E);
    set_time(20, 7, 9, 12, 59, 59, 1);
    bus_write('h0E, 8'hFC);
    do_tick(); bus_read('h0E, b); check("R8 hour", b, 8'h1E);
    set_time(20, 7, 9, 23, 59, 59, 1);
    bus_write('h0E, 8'hFC);
    do_tick(); bus_read('h0E, b); check("R8 day", b, 8'h3E);

    // R10 write-one-to-clear
    bus_write('h0E, 8'h00); bus_read('h0E, b); check("R10 zero write", b, 8'h3E);
    bus_write('h0E, 8'h03); bus_read('h0E, b); check("R10 low bits ignored", b, 8'h3E);
    bus_write('h0E, 8'h08); bus_read('h0E, b); check("R10 single clear", b, 8'h36);
    bus_write('h0E, 8'hFF); bus_read('h0E, b); check("R10 clear all", b, 8'h02);

    // R11 periodic interrupt for every interval code
    for (int c = 0; c < 4; c++) begin
      set_time(1, 1, 1, 23, 59, 58, 0);
      bus_write('h0E, 8'hFC);
      bus_write('h0F, 8'(4 | c));
      check("R11 idle", irq, 1'b0);
      do_tick();
      check("R11 plain second", irq, (c == 0));
      bus_write('h0E, 8'hFC);
      check("R11 cleared", irq, 1'b0);
      do_tick();
      check("R11 midnight", irq, 1'b1);
      bus_write('h0E, 8'hFC);
      check("R11 cleared again", irq, 1'b0);
    end
    bus_write('h0F, 8'h00);

    // R9 alarm match, weekday ignored
    set_time(5, 6, 15, 10, 20, 30, 2);
    bus_write('h07, 8'h33); bus_write('h08, 8'h20); bus_write('h09, 8'h10);
    bus_write('h0A, 8'h15); bus_write('h0B, 8'h06); bus_write('h0C, 8'h05);
    bus_write('h0E, 8'hFC);
    bus_write('h0F, 8'h08);
    do_tick(); do_tick();
    bus_read('h0E, b); check("R9 not yet", b[6], 1'b0);
    check("R11 alarm irq low", irq, 1'b0);
    do_tick();
    bus_read('h0E, b); check("R9 match", b[6], 1'b1);
    check("R11 alarm irq high", irq, 1'b1);
    bus_write('h0E, 8'h40);
    check("R11 alarm irq cleared", irq, 1'b0);
    bus_read('h0E, b); check("R10 alarm flag cleared", b[6], 1'b0);
    bus_write('h0F, 8'h00);
    set_time(5, 6, 15, 10, 20, 32, 4);
    do_tick();
    bus_read('h0E, b); check("R9 match other weekday", b[6], 1'b1);
    check("R11 alarm disabled irq", irq, 1'b0);
    bus_write('h0A, 8'h00);

    // R7 snapshot
    set_time(10, 3, 5, 8, 0, 0, 1);
    do_tick(); model_tick();
    bus_write('h0D, 8'h41);
    snap = model_word();
    do_tick(); model_tick();
    do_tick(); model_tick();
    read_time(t); check("R7 shadow held", t, snap);
    bus_write('h0D, 8'h41);
    read_time(t); check("R7 shadow refreshed", t, model_word());
    do_tick(); model_tick();
    bus_write('h0D, 8'h01);
    read_time(t); check("R7 live view", t, model_word());

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule